// File: doc/BRIEF.md
# Two-Player Score Keeper

This block tallies points for a two-player button game. Each side delivers a one-cycle win strobe. The block keeps a 3-bit score for each side and shows it as a decimal digit on that side's 7-segment display. It also sends a restart strobe to the playfield logic so that a new round begins automatically.

A global reset clears both scores and restarts the playfield. A win restarts only the playfield and leaves both scores in place. A score stops at 7, because the game is over at that point.

Top module: `score_keeper`

## Requirements
- R1: After a synchronous active-high reset, both scores are 0, so both displays show the digit 0. With active-low outputs in bit order {g,f,e,d,c,b,a}, that pattern is 7'b1000000.
- R2: A win strobe for one player raises that player's score by exactly 1. The new digit appears on the display in the cycle after the strobe.
- R3: A win strobe for one player does not change the other player's score.
- R4: A score that has reached 7 stays at 7 when further wins arrive (saturation).
- R5: The restart output goes high for exactly one cycle, in the cycle after any win strobe is sampled. It is low in every other cycle.
- R6: If both win strobes arrive in the same cycle, both scores increment and only one restart cycle is produced.
- R7: Reset has priority over win strobes. It clears both scores and asserts restart in the cycle after reset is sampled.
- R8: Each display uses active-low segments in bit order {g,f,e,d,c,b,a}. Digits 0 to 7 are 40,79,24,30,19,12,02,78 in hex.
- R9: A win changes neither score except through R2 and R4. Scores hold their values in any cycle without a win strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| win_left | input | 1 | One-cycle win strobe, left player |
| win_right | input | 1 | One-cycle win strobe, right player |
| seg_left | output | 7 | Left score digit, active-low {g,f,e,d,c,b,a} |
| seg_right | output | 7 | Right score digit, active-low {g,f,e,d,c,b,a} |
| restart | output | 1 | Playfield restart strobe |

## Verification
The hardest situation to reach from the ports is a score sitting at 7 and receiving further wins, especially when the other player wins in the same cycle. Random strobes alone reach this slowly and unevenly. The bench therefore uses a seeded random phase with a high win probability so that both scores climb to saturation. It also uses directed sequences that drive one side to 7, then issue simultaneous wins, then assert reset together with wins.

// File: rtl/score_pkg.sv
package score_pkg;
    parameter int SCORE_W = 3;
    parameter int SEG_W   = 7;
    localparam logic [SCORE_W-1:0] SCORE_MAX = {SCORE_W{1'b1}};

    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/score_counter.sv
module score_counter
    import score_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bump,
    output score_t value
);
    typedef struct packed {
        score_t cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (bump && st_q.cnt != SCORE_MAX) begin
            st_d.cnt = st_q.cnt + score_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value = st_q.cnt;

    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q.cnt) == SCORE_MAX && !$past(rst)) |-> st_q.cnt == SCORE_MAX);
    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bump) && $past(st_q.cnt) != SCORE_MAX) |-> st_q.cnt == $past(st_q.cnt) + score_t'(1));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bump)) |-> $stable(st_q.cnt));
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import score_pkg::*;
(
    input  score_t digit,
    output seg_t   segs
);
    seg_t lit;

    // lit holds the active-high segments in bit order {g,f,e,d,c,b,a}.
    always_comb begin
        case (digit)
            3'd0:    lit = 7'b0111111;
            3'd1:    lit = 7'b0000110;
            3'd2:    lit = 7'b1011011;
            3'd3:    lit = 7'b1001111;
            3'd4:    lit = 7'b1100110;
            3'd5:    lit = 7'b1101101;
            3'd6:    lit = 7'b1111101;
            default: lit = 7'b0000111;
        endcase
    end

    assign segs = ~lit;
endmodule

// File: rtl/restart_gen.sv
module restart_gen (
    input  logic clk,
    input  logic rst,
    input  logic any_win,
    output logic restart
);
    typedef struct packed {
        logic pulse;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = rst | any_win;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign restart = st_q.pulse;
endmodule

// File: rtl/score_keeper.sv
module score_keeper
    import score_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             win_left,
    input  logic             win_right,
    output logic [SEG_W-1:0] seg_left,
    output logic [SEG_W-1:0] seg_right,
    output logic             restart
);
    localparam int PLAYERS = 2;

    logic   [PLAYERS-1:0] wins;
    score_t               score [PLAYERS];
    seg_t                 segs  [PLAYERS];

    assign wins = {win_right, win_left};

    for (genvar p = 0; p < PLAYERS; p++) begin : g_player
        score_counter u_cnt (
            .clk  (clk),
            .rst  (rst),
            .bump (wins[p]),
            .value(score[p])
        );
        seg_decoder u_seg (
            .digit(score[p]),
            .segs (segs[p])
        );
    end

    restart_gen u_rs (
        .clk    (clk),
        .rst    (rst),
        .any_win(|wins),
        .restart(restart)
    );

    assign seg_left  = segs[0];
    assign seg_right = segs[1];

    // R5
    restart_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wins) != '0) |-> restart);
    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wins) == '0) |-> !restart);
    // R7
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (score[0] == '0 && score[1] == '0 && restart));
    // R3
    left_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(win_left)) |-> $stable(score[0]));
endmodule

// File: tb/tb_score_keeper.sv
module tb_score_keeper;
    logic clk = 0;
    logic rst, wl, wr;
    logic [6:0] sl, sr;
    logic rs;
    int checks = 0, errors = 0;
    int exp_l = 0, exp_r = 0;

    always #5 clk = ~clk;

    score_keeper dut (
        .clk(clk), .rst(rst), .win_left(wl), .win_right(wr),
        .seg_left(sl), .seg_right(sr), .restart(rs)
    );

    function automatic logic [6:0] seg_of(int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; default: return 7'h78;
        endcase
    endfunction

    task automatic chk(string req, logic [6:0] act, logic [6:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One cycle: inputs are applied away from the edge, the edge happens, and the outputs are checked at the negedge.
    task automatic step(logic r, logic l, logic ri, string req);
        logic exp_rs;
        wl = l; wr = ri; rst = r;
        @(posedge clk);
        exp_rs = r | l | ri;
        if (r) begin exp_l = 0; exp_r = 0; end
        else begin
            if (l && exp_l < 7) exp_l++;
            if (ri && exp_r < 7) exp_r++;
        end
        @(negedge clk);
        chk({req, " left"},  sl, seg_of(exp_l));
        chk({req, " right"}, sr, seg_of(exp_r));
        chk({req, " restart"}, {6'b0, rs}, {6'b0, exp_rs});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        wl = 0; wr = 0; rst = 1;
        @(negedge clk);
        step(1, 0, 0, "R1 reset");
        step(0, 0, 0, "R5 idle quiet");
        step(0, 1, 0, "R2 left win");
        step(0, 0, 0, "R9 hold");
        step(0, 0, 1, "R3 right win only");
        step(0, 1, 1, "R6 both win");
        for (int i = 0; i < 8; i++) step(0, 1, 0, "R4 left to saturation");
        step(0, 1, 1, "R4 R6 both with left saturated");
        for (int i = 0; i < 8; i++) step(0, 0, 1, "R8 right digits");
        step(1, 1, 1, "R7 reset beats wins");
        step(0, 0, 0, "R1 after reset");
        for (int i = 0; i < 400; i++) begin
            logic rr, ll, rrw;
            rr  = ($urandom % 40) == 0;
            ll  = ($urandom % 3) == 0;
            rrw = ($urandom % 3) == 0;
            step(rr, ll, rrw, "R2 R4 R5 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule